// File: doc/BRIEF.md
# Indirect Register Window for a Voice Codec Peripheral

This block is the byte-wide window through which a processor programs a telephony/audio peripheral. A 3-bit address bus reaches a handful of direct registers. Most settings sit in an internal indexed space. Software writes an index into the command register and then moves bytes through the data register. Multi-byte gain registers are filled through a byte pointer that steps on each data access and starts again at zero whenever a new index is written.

A pending-interrupt register shares the command register's address. A read of that address returns the eight pending source flags and clears them in the same access. The interrupt output is the OR of the enabled pending flags. Two channel buffer addresses let software send a transmit byte and collect a received byte. The analog path, the line unit and the framing logic are outside this block; their events arrive as single-cycle pulses.

Top module: `codec_regwin`

## Requirements
- R1: After reset, all indexed registers, the pending flags, `irq` and `tx_byte` are zero.
- R2: A read at address 0 returns the pending flags and clears them at that clock edge. A pulse on `src_evt[i]` sets flag `i`. Bit 0 is D-transmit threshold, bit 1 D-receive threshold, bit 2 D packet status, bit 3 D error, bit 4 B-channel byte transfer, bit 5 line-unit status, bit 6 D buffer status and bit 7 multiframe.
- R3: A source pulse in the same cycle as a clearing read is not lost; it is pending afterwards.
- R4: `irq` is high when any enabled flag is pending. Flag 4 counts only while bit 3 (0x08) of index 0x44 is set. While bit 2 (0x04) of index 0x21 is set, `irq` stays low.
- R5: Writing address 0 selects an index, and data accesses at address 1 then reach it. The one-byte indices 0x21, 0x41, 0x44 and 0x69 read back what was written. `ctl_init` shows index 0x21. `route_src` and `route_dst` show the low and high nibbles of index 0x41. `alaw_sel` is bit 0 of index 0x69.
- R6: Indices 0x63 to 0x66 are 16-bit gains, written and read low byte first, then high byte. Index 0x63+k appears on `gain_vec[16k+15:16k]`.
- R7: The byte pointer returns to 0 on every command write. Once all bytes of the selected register have been accessed, further data writes change nothing and further data reads return 0x00.
- R8: An index that is not implemented reads 0x00, and writing it changes no register.
- R9: A write to address 5 or 6 sets `tx_byte`, and a read there returns `rx_byte`. Reads of addresses 2, 3, 4 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 3 | Direct register address |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the current address (combinational) |
| src_evt | input | 8 | Interrupt source pulses |
| rx_byte | input | 8 | Received channel byte |
| tx_byte | output | 8 | Transmit channel byte |
| irq | output | 1 | Interrupt request |
| ctl_init | output | 8 | Initialisation/control register |
| route_src | output | 4 | Routing source channel code |
| route_dst | output | 4 | Routing destination channel code |
| alaw_sel | output | 1 | 1 = A-law, 0 = mu-law |
| gain_vec | output | 64 | Four 16-bit gain words |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high together. They also assume each strobe lasts one cycle per access, because the byte pointer and the clear-on-read act at every edge where a strobe is high. The bench drives strobes at the falling edge and drops them one cycle later, and it never raises both at once. It samples `cpu_rdata` before the rising edge that commits the access. Source pulses last a single cycle. One pulse is placed on the exact edge of a clearing read, to exercise the case where a new event meets a clear.

// File: rtl/codec_regwin_pkg.sv
package codec_regwin_pkg;
  localparam int NUM_SRC    = 8;
  localparam int GAIN_W     = 16;
  localparam int NUM_GAIN   = 4;
  localparam int GAIN_BYTES = GAIN_W / 8;
  localparam int PTR_W      = $clog2(GAIN_BYTES + 1);
  localparam int BSEL_W     = $clog2(GAIN_BYTES);

  localparam logic [7:0] IDX_INIT   = 8'h21;
  localparam logic [7:0] IDX_ROUTE  = 8'h41;
  localparam logic [7:0] IDX_MUXCTL = 8'h44;
  localparam logic [7:0] IDX_GAIN0  = 8'h63;
  localparam logic [7:0] IDX_MODE   = 8'h69;

  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_DATA = 3'd1;
  localparam logic [2:0] A_CHA  = 3'd5;
  localparam logic [2:0] A_CHB  = 3'd6;

  localparam int BXFER_BIT = 4;

  // number of bytes behind an index; 0 means not implemented
  function automatic logic [PTR_W-1:0] reg_bytes(input logic [7:0] idx);
    if (idx >= IDX_GAIN0 && idx < IDX_GAIN0 + 8'(NUM_GAIN))
      return PTR_W'(GAIN_BYTES);
    case (idx)
      IDX_INIT, IDX_ROUTE, IDX_MUXCTL, IDX_MODE: return PTR_W'(1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/codec_irq_stat.sv
module codec_irq_stat
  import codec_regwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src,
  input  logic               clr,
  input  logic [NUM_SRC-1:0] en_mask,
  input  logic               mask_all,
  output logic [NUM_SRC-1:0] pend,
  output logic               irq
);
  logic [NUM_SRC-1:0] pend_kept;

  assign pend_kept = clr ? '0 : pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_kept | src;
  end

  assign irq = !mask_all && |(pend & en_mask);

  AST_CLR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && src == '0) |=> pend == '0);  // R2
  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (|src) |=> ((pend & $past(src)) == $past(src)));  // R3
endmodule

// File: rtl/codec_ind_regs.sv
module codec_ind_regs
  import codec_regwin_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_wr,
  input  logic                       dat_wr,
  input  logic                       dat_rd,
  input  logic [7:0]                 wdata,
  output logic [7:0]                 rdata,
  output logic [7:0]                 init_q,
  output logic [7:0]                 route_q,
  output logic                       bxfer_en,
  output logic                       alaw,
  output logic [NUM_GAIN*GAIN_W-1:0] gain_q
);
  logic [7:0]       sel;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] nbytes;
  logic             acc_ok, wr_ok, step;
  logic [7:0]       muxctl_q, mode_q;
  logic [7:0]       gain_rd;

  assign nbytes = reg_bytes(sel);
  assign acc_ok = ptr < nbytes;
  assign wr_ok  = dat_wr && acc_ok;
  assign step   = (dat_wr || dat_rd) && acc_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel <= '0;
      ptr <= '0;
    end else if (cmd_wr) begin
      sel <= wdata;
      ptr <= '0;
    end else if (step) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q   <= '0;
      route_q  <= '0;
      muxctl_q <= '0;
      mode_q   <= '0;
    end else if (wr_ok) begin
      case (sel)
        IDX_INIT:   init_q   <= wdata;
        IDX_ROUTE:  route_q  <= wdata;
        IDX_MUXCTL: muxctl_q <= wdata;
        IDX_MODE:   mode_q   <= wdata;
        default: ;
      endcase
    end
  end

  logic [BSEL_W-1:0] bsel;
  assign bsel = ptr[BSEL_W-1:0];

  logic [NUM_GAIN-1:0][7:0] gain_byte;

  for (genvar k = 0; k < NUM_GAIN; k++) begin : g_gain
    logic [GAIN_W-1:0] word_q;
    logic              hit;
    assign hit = (sel == IDX_GAIN0 + 8'(k));
    always_ff @(posedge clk) begin
      if (!rst_n)            word_q <= '0;
      else if (wr_ok && hit) word_q[8*bsel +: 8] <= wdata;
    end
    assign gain_byte[k] = hit ? word_q[8*bsel +: 8] : 8'h00;
    assign gain_q[GAIN_W*k +: GAIN_W] = word_q;
  end

  always_comb begin
    gain_rd = '0;
    for (int k = 0; k < NUM_GAIN; k++) gain_rd = gain_rd | gain_byte[k];
  end

  always_comb begin
    rdata = 8'h00;
    if (acc_ok) begin
      case (sel)
        IDX_INIT:   rdata = init_q;
        IDX_ROUTE:  rdata = route_q;
        IDX_MUXCTL: rdata = muxctl_q;
        IDX_MODE:   rdata = mode_q;
        default:    rdata = gain_rd;
      endcase
    end
  end

  assign bxfer_en = muxctl_q[3];
  assign alaw     = mode_q[0];

  AST_PTR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> ptr == '0);  // R7
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= nbytes);  // R7
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(gain_q));  // R6
endmodule

// File: rtl/codec_regwin.sv
module codec_regwin
  import codec_regwin_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [2:0]                 cpu_addr,
  input  logic                       cpu_wr,
  input  logic                       cpu_rd,
  input  logic [7:0]                 cpu_wdata,
  output logic [7:0]                 cpu_rdata,
  input  logic [NUM_SRC-1:0]         src_evt,
  input  logic [7:0]                 rx_byte,
  output logic [7:0]                 tx_byte,
  output logic                       irq,
  output logic [7:0]                 ctl_init,
  output logic [3:0]                 route_src,
  output logic [3:0]                 route_dst,
  output logic                       alaw_sel,
  output logic [NUM_GAIN*GAIN_W-1:0] gain_vec
);
  logic cmd_wr, ir_rd, dat_wr, dat_rd, ch_hit, ch_wr;
  logic [7:0] ind_rdata, route_q;
  logic [NUM_SRC-1:0] pend, en_mask;
  logic bxfer_en;

  assign cmd_wr = cpu_wr && cpu_addr == A_CMD;
  assign ir_rd  = cpu_rd && cpu_addr == A_CMD;
  assign dat_wr = cpu_wr && cpu_addr == A_DATA;
  assign dat_rd = cpu_rd && cpu_addr == A_DATA;
  assign ch_hit = cpu_addr == A_CHA || cpu_addr == A_CHB;
  assign ch_wr  = cpu_wr && ch_hit;

  codec_ind_regs i_ind (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dat_wr(dat_wr),
    .dat_rd(dat_rd), .wdata(cpu_wdata), .rdata(ind_rdata),
    .init_q(ctl_init), .route_q(route_q), .bxfer_en(bxfer_en),
    .alaw(alaw_sel), .gain_q(gain_vec)
  );

  always_comb begin
    en_mask = '1;
    en_mask[BXFER_BIT] = bxfer_en;
  end

  codec_irq_stat i_irq (
    .clk(clk), .rst_n(rst_n), .src(src_evt), .clr(ir_rd),
    .en_mask(en_mask), .mask_all(ctl_init[2]), .pend(pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     tx_byte <= '0;
    else if (ch_wr) tx_byte <= cpu_wdata;
  end

  always_comb begin
    if (cpu_addr == A_CMD)       cpu_rdata = pend;
    else if (cpu_addr == A_DATA) cpu_rdata = ind_rdata;
    else if (ch_hit)             cpu_rdata = rx_byte;
    else                         cpu_rdata = 8'h00;
  end

  assign route_src = route_q[3:0];
  assign route_dst = route_q[7:4];

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_wr |=> $stable(tx_byte));  // R9
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rd && cpu_wr));  // R2
endmodule

// File: tb/test_codec_regwin.sv
module test_codec_regwin;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  cpu_addr = 0;
  logic        cpu_wr = 0, cpu_rd = 0;
  logic [7:0]  cpu_wdata = 0, cpu_rdata;
  logic [7:0]  src_evt = 0, rx_byte = 0, tx_byte, ctl_init;
  logic        irq, alaw_sel;
  logic [3:0]  route_src, route_dst;
  logic [63:0] gain_vec;
  int n_chk = 0, n_bad = 0;

  codec_regwin i_codec_regwin (.*);

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(posedge clk); #1 cpu_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cpu_addr = a; cpu_rd = 1;
    #2 d = cpu_rdata;
    @(posedge clk); #1 cpu_rd = 0;
  endtask

  task automatic pulse(input logic [7:0] s);
    @(negedge clk); src_evt = s;
    @(posedge clk); #1 src_evt = 0;
  endtask

  task automatic settle; @(negedge clk); endtask

  task automatic t_reset;
    logic [7:0] v;
    settle;
    check("R1 irq", irq, 0);
    check("R1 tx_byte", tx_byte, 0);
    check("R1 gains", gain_vec, 0);
    check("R1 init", ctl_init, 0);
    rd(0, v); check("R1 pending", v, 0);
  endtask

  task automatic t_clear;
    logic [7:0] v;
    pulse(8'h01); pulse(8'h80);
    settle; check("R4 irq on pending", irq, 1);
    rd(0, v); check("R2 bitmask", v, 8'h81);
    rd(0, v); check("R2 cleared", v, 8'h00);
    settle; check("R4 irq idle", irq, 0);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    pulse(8'h02);
    @(negedge clk); cpu_addr = 0; cpu_rd = 1; src_evt = 8'h20;
    #2 v = cpu_rdata;
    @(posedge clk); #1 begin cpu_rd = 0; src_evt = 0; end
    check("R3 read value", v, 8'h02);
    rd(0, v); check("R3 survived", v, 8'h20);
  endtask

  task automatic t_gating;
    logic [7:0] v;
    pulse(8'h10);
    settle; check("R4 bxfer disabled", irq, 0);
    wr(0, 8'h44); wr(1, 8'h08);
    settle; check("R4 bxfer enabled", irq, 1);
    wr(0, 8'h21); wr(1, 8'h05);
    settle; check("R4 masked", irq, 0);
    check("R5 ctl_init", ctl_init, 8'h05);
    rd(0, v); check("R2 bit4", v, 8'h10);
    wr(0, 8'h21); wr(1, 8'h01);
  endtask

  task automatic t_single;
    logic [7:0] v;
    wr(0, 8'h41); wr(1, 8'h43);
    settle;
    check("R5 route_src", route_src, 4'h3);
    check("R5 route_dst", route_dst, 4'h4);
    wr(0, 8'h41); rd(1, v); check("R5 route readback", v, 8'h43);
    wr(0, 8'h69); wr(1, 8'h01);
    settle; check("R5 alaw", alaw_sel, 1);
    wr(0, 8'h69); wr(1, 8'h00);
    settle; check("R5 mulaw", alaw_sel, 0);
  endtask

  task automatic t_gain;
    logic [7:0] v;
    wr(0, 8'h63); wr(1, 8'h34); wr(1, 8'h12);
    wr(0, 8'h66); wr(1, 8'hcd); wr(1, 8'hab);
    settle; check("R6 gain_vec", gain_vec, 64'habcd_0000_0000_1234);
    wr(0, 8'h66); rd(1, v); check("R6 low byte", v, 8'hcd);
    rd(1, v); check("R6 high byte", v, 8'hab);
    rd(1, v); check("R7 read past end", v, 8'h00);
    wr(1, 8'h77);
    settle; check("R7 write past end", gain_vec, 64'habcd_0000_0000_1234);
    wr(0, 8'h63); wr(1, 8'h99);
    wr(0, 8'h63); rd(1, v); check("R7 pointer restart", v, 8'h99);
    wr(0, 8'h41); rd(1, v); rd(1, v); check("R7 one-byte end", v, 8'h00);
  endtask

  task automatic t_unimpl;
    logic [7:0] v;
    wr(0, 8'h6c); wr(1, 8'hff); wr(1, 8'hff);
    rd(1, v); check("R8 read zero", v, 8'h00);
    settle; check("R8 gains untouched", gain_vec, 64'habcd_0000_0000_1299);
    wr(0, 8'h41); rd(1, v); check("R8 route untouched", v, 8'h43);
  endtask

  task automatic t_chan;
    logic [7:0] v;
    rx_byte = 8'h5a;
    wr(5, 8'hc3); settle; check("R9 tx via 5", tx_byte, 8'hc3);
    wr(6, 8'h3c); settle; check("R9 tx via 6", tx_byte, 8'h3c);
    rd(5, v); check("R9 rx via 5", v, 8'h5a);
    rd(6, v); check("R9 rx via 6", v, 8'h5a);
    rd(3, v); check("R9 addr 3", v, 8'h00);
    rd(7, v); check("R9 addr 7", v, 8'h00);
    wr(2, 8'h11); settle; check("R9 tx kept", tx_byte, 8'h3c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset;
    t_clear;
    t_same_cycle;
    t_gating;
    t_single;
    t_gain;
    t_unimpl;
    t_chan;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule